// File: doc/BRIEF.md
# Dual-Channel Mirrored Interrupt Status

This block keeps the interrupt-pending and interrupt-block state of a two-channel storage controller and drives one level-sensitive interrupt request. Each channel's pending flag is visible at two places in a byte-addressed configuration space: a per-channel legacy status byte and a shared mode byte. Software may read or clear the flag through either place, and the two views never disagree. A separate DMA register port can write the mode byte, and only its two block bits can change that way. While a channel's block bit is set, that channel cannot raise the interrupt request.

Configuration accesses are dword-addressed (byte address bits [7:2]) with four byte enables. Lane n carries byte address 4*dword+n in data bits [8n+7:8n]. Reads are combinational and side-effect free. Writes take effect on the clock edge where `cfg_wr_en` is sampled high. There is no back-pressure: every write strobe is accepted in the cycle it is presented. The same holds for `dma_wr_en`. A channel's interrupt line is a level, sampled on every clock.

The layout is fixed by the neighbours that decode it. Channel 0 pending is bit 2 of byte 0x50 and bit 2 of byte 0x71. Channel 1 pending is bit 4 of byte 0x57 and bit 3 of byte 0x71. The block bits are bit 4 (channel 0) and bit 5 (channel 1) of byte 0x71. The channel-enable byte sits at 0x51.

Top module: `irq_mirror_ctl`

## Requirements
- R1: While reset is asserted (synchronous, active low), all pending and block bits clear and `irq_out` goes low. Byte 0x51 loads 0x04, with bit 3 also set when `sec_en_strap` is high during reset.
- R2: A change of `irq_line[n]` sets or clears channel n's pending flag, to match the line's new level, at the first clock edge that samples the change. The flag is visible in both its locations: bit 2 of 0x50 and bit 2 of 0x71 for channel 0, and bit 4 of 0x57 and bit 3 of 0x71 for channel 1.
- R3: A configuration write with a 1 in a pending bit, at either of its two locations, clears that flag in both locations. A 0 leaves the flag unchanged, and no configuration write ever sets a pending flag.
- R4: In one multi-byte write, every enabled lane applies its effects in the same edge. A lane whose byte enable is 0 has no effect.
- R5: A DMA port write updates only the block bits, from `dma_wdata[5:4]`, and leaves the pending flags unchanged. Configuration writes to 0x71 never change the block bits. `dma_rd_data` returns byte 0x71.
- R6: `irq_out` is the OR, over both channels, of pending AND NOT blocked, and it changes one clock after the state it reflects.
- R7: Byte 0x51 is fully writable under its byte enable. All bits of 0x50, 0x57 and 0x71 other than those named in R2 and R5 read 0 and ignore writes.
- R8: Every configuration byte outside 0x50, 0x51, 0x57 and 0x71 reads 0.
- R9: When a line change and a clear of the same channel land on the same edge, the line change decides the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_en_strap | input | 1 | Secondary channel enable value loaded at reset |
| irq_line | input | 2 | Per-channel interrupt level lines |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 6 | Configuration write dword address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Configuration write byte enables |
| cfg_rd_addr | input | 6 | Configuration read dword address |
| cfg_rd_data | output | 32 | Configuration read data |
| dma_wr_en | input | 1 | DMA port mode-byte write strobe |
| dma_wdata | input | 8 | DMA port mode-byte write data |
| dma_rd_data | output | 8 | Mode byte as seen by the DMA port |
| irq_out | output | 1 | Combined level interrupt request |

## Verification
The bench clears each flag through the copy opposite to the one it then reads. A design that stored two independent copies would show a stale 1 in the other byte. It sends writes with a clear bit in a disabled lane, and writes that clear and set the control byte together. A design that ignored byte enables, or applied only one lane, would clear a flag that should survive or lose the control write. It also writes all-ones to the mode byte through both ports, which would expose a design that let DMA data touch pending bits or let configuration data set block bits. Finally, it lands a rising line and a clear on the same edge; a design that gave the clear priority would drop a real interrupt.

// File: rtl/irq_mirror_pkg.sv
package irq_mirror_pkg;
  localparam int NCH    = 2;
  localparam int AW     = 6;
  localparam int LANES  = 4;
  localparam int DW     = 8 * LANES;

  // dword addresses of the bytes this block owns
  localparam logic [AW-1:0] DWA_STAT0 = 6'h14; // bytes 0x50..0x53
  localparam logic [AW-1:0] DWA_STAT1 = 6'h15; // bytes 0x54..0x57
  localparam logic [AW-1:0] DWA_MODE  = 6'h1C; // bytes 0x70..0x73

  localparam int LN_STAT0 = 0; // byte 0x50
  localparam int LN_CHEN  = 1; // byte 0x51
  localparam int LN_STAT1 = 3; // byte 0x57
  localparam int LN_MODE  = 1; // byte 0x71

  localparam int BP_STAT0_PEND = 2;
  localparam int BP_STAT1_PEND = 4;
  localparam int BP_MODE_PEND0 = 2; // channel n at BP_MODE_PEND0 + n
  localparam int BP_MODE_BLK0  = 4; // channel n at BP_MODE_BLK0 + n

  localparam logic [7:0] CHEN_RST = 8'h04;
  localparam int BP_CHEN_SEC = 3;

  typedef struct packed {
    logic [NCH-1:0] clr;
    logic           chen_we;
    logic [7:0]     chen_wd;
  } cfg_cmd_t;

  function automatic logic [7:0] lane_of(input logic [DW-1:0] d, input int ln);
    return d[8*ln +: 8];
  endfunction
endpackage

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irq_mirror_pkg::*;
(
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] be,
  output cfg_cmd_t         cmd
);
  logic hit_s0, hit_s1, hit_md;
  logic [7:0] b_s0, b_s1, b_md;

  always_comb begin
    hit_s0 = wr_en && (wr_addr == DWA_STAT0);
    hit_s1 = wr_en && (wr_addr == DWA_STAT1);
    hit_md = wr_en && (wr_addr == DWA_MODE);
    b_s0   = lane_of(wdata, LN_STAT0);
    b_s1   = lane_of(wdata, LN_STAT1);
    b_md   = lane_of(wdata, LN_MODE);

    // clears from the legacy bytes and the mode byte are gathered in one step
    cmd.clr[0] = (hit_s0 && be[LN_STAT0] && b_s0[BP_STAT0_PEND]) ||
                 (hit_md && be[LN_MODE]  && b_md[BP_MODE_PEND0]);
    cmd.clr[1] = (hit_s1 && be[LN_STAT1] && b_s1[BP_STAT1_PEND]) ||
                 (hit_md && be[LN_MODE]  && b_md[BP_MODE_PEND0 + 1]);

    cmd.chen_we = hit_s0 && be[LN_CHEN];
    cmd.chen_wd = lane_of(wdata, LN_CHEN);
  end
endmodule

// File: rtl/irq_chan_state.sv
module irq_chan_state (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic clr,
  input  logic blk_we,
  input  logic blk_wd,
  output logic pend,
  output logic blk,
  output logic active
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend   <= 1'b0;
      blk    <= 1'b0;
    end else begin
      line_q <= line;
      if (line != line_q) pend <= line;
      else if (clr)       pend <= 1'b0;
      if (blk_we) blk <= blk_wd;
    end
  end

  assign active = pend && !blk;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_mirror_pkg::*;
(
  input  logic [AW-1:0]  rd_addr,
  input  logic [NCH-1:0] pend,
  input  logic [NCH-1:0] blk,
  input  logic [7:0]     chen,
  output logic [DW-1:0]  rd_data,
  output logic [7:0]     mode_byte
);
  logic [7:0] s0, s1;

  always_comb begin
    s0 = '0;
    s0[BP_STAT0_PEND] = pend[0];
    s1 = '0;
    s1[BP_STAT1_PEND] = pend[1];
    mode_byte = '0;
    for (int n = 0; n < NCH; n++) begin
      mode_byte[BP_MODE_PEND0 + n] = pend[n];
      mode_byte[BP_MODE_BLK0 + n]  = blk[n];
    end

    rd_data = '0;
    unique case (rd_addr)
      DWA_STAT0: begin
        rd_data[8*LN_STAT0 +: 8] = s0;
        rd_data[8*LN_CHEN  +: 8] = chen;
      end
      DWA_STAT1: rd_data[8*LN_STAT1 +: 8] = s1;
      DWA_MODE:  rd_data[8*LN_MODE  +: 8] = mode_byte;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_mirror_ctl.sv
module irq_mirror_ctl
  import irq_mirror_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_en_strap,
  input  logic [NCH-1:0]   irq_line,
  input  logic             cfg_wr_en,
  input  logic [AW-1:0]    cfg_wr_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [LANES-1:0] cfg_be,
  input  logic [AW-1:0]    cfg_rd_addr,
  output logic [DW-1:0]    cfg_rd_data,
  input  logic             dma_wr_en,
  input  logic [7:0]       dma_wdata,
  output logic [7:0]       dma_rd_data,
  output logic             irq_out
);
  cfg_cmd_t       cmd;
  logic [NCH-1:0] pend, blk, active;
  logic [7:0]     chen;

  irq_cfg_decode u_dec (
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wdata(cfg_wdata),
    .be(cfg_be), .cmd(cmd)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    irq_chan_state u_ch (
      .clk(clk), .rst_n(rst_n), .line(irq_line[n]), .clr(cmd.clr[n]),
      .blk_we(dma_wr_en), .blk_wd(dma_wdata[BP_MODE_BLK0 + n]),
      .pend(pend[n]), .blk(blk[n]), .active(active[n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chen <= CHEN_RST | (8'(sec_en_strap) << BP_CHEN_SEC);
      irq_out <= 1'b0;
    end else begin
      if (cmd.chen_we) chen <= cmd.chen_wd;
      irq_out <= |active;
    end
  end

  irq_read_mux u_rd (
    .rd_addr(cfg_rd_addr), .pend(pend), .blk(blk), .chen(chen),
    .rd_data(cfg_rd_data), .mode_byte(dma_rd_data)
  );
endmodule

// File: rtl/irq_mirror_chk.sv
module irq_mirror_chk
  import irq_mirror_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   irq_line,
  input logic             cfg_wr_en,
  input logic [AW-1:0]    cfg_wr_addr,
  input logic [DW-1:0]    cfg_wdata,
  input logic [LANES-1:0] cfg_be,
  input logic             dma_wr_en,
  input logic [NCH-1:0]   pend,
  input logic [NCH-1:0]   blk,
  input logic [7:0]       chen,
  input logic             irq_out
);
  AST_IRQ_LAGS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(pend & ~blk))); // R6

  AST_CH0_SET_BY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(irq_line[0])); // R3

  AST_CH1_SET_BY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[1]) |-> $past(irq_line[1])); // R3

  AST_BLK_ONLY_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_wr_en |=> $stable(blk)); // R5

  AST_W1C_LEGACY0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg_wr_en && cfg_wr_addr == DWA_STAT0 && cfg_be[LN_STAT0] &&
     cfg_wdata[8*LN_STAT0 + BP_STAT0_PEND] && irq_line[0] == $past(irq_line[0]))
    |=> !pend[0]); // R3

  AST_CHEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && cfg_wr_addr == DWA_STAT0 && cfg_be[LN_CHEN]) |=> $stable(chen)); // R7
endmodule

bind irq_mirror_ctl irq_mirror_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .cfg_wr_en(cfg_wr_en),
  .cfg_wr_addr(cfg_wr_addr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
  .dma_wr_en(dma_wr_en), .pend(pend), .blk(blk), .chen(chen), .irq_out(irq_out)
);

// File: tb/sim_irq_mirror_ctl.sv
`timescale 1ns/1ps
module sim_irq_mirror_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_en_strap = 1'b0;
  logic [1:0] irq_line = '0;
  logic cfg_wr_en = 1'b0;
  logic [5:0] cfg_wr_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0] cfg_be = '0;
  logic [5:0] cfg_rd_addr = '0;
  logic [31:0] cfg_rd_data;
  logic dma_wr_en = 1'b0;
  logic [7:0] dma_wdata = '0;
  logic [7:0] dma_rd_data;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [1:0] mp, mb;
  logic [7:0] mchen;

  always #4 clk = ~clk;

  irq_mirror_ctl u0 (
    .clk(clk), .rst_n(rst_n), .sec_en_strap(sec_en_strap), .irq_line(irq_line),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wdata(cfg_wdata),
    .cfg_be(cfg_be), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .dma_wr_en(dma_wr_en), .dma_wdata(dma_wdata), .dma_rd_data(dma_rd_data),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    cfg_rd_addr = a;
    #1;
    d = cfg_rd_data;
  endtask

  function automatic logic [7:0] mode_exp();
    return {2'b00, mb[1], mb[0], mp[1], mp[0], 2'b00};
  endfunction

  task automatic chk_state(input string tag);
    logic [31:0] d;
    rd(6'h14, d); chk({tag, " 0x50/0x51"}, d, {16'h0, mchen, 5'b0, mp[0], 2'b0});
    rd(6'h15, d); chk({tag, " 0x57"}, d, {3'b0, mp[1], 28'h0});
    rd(6'h1C, d); chk({tag, " 0x71"}, d, {16'h0, mode_exp(), 8'h0});
    chk({tag, " dma rd"}, {24'h0, dma_rd_data}, {24'h0, mode_exp()});
  endtask

  task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic set_lines(input logic [1:0] v);
    @(negedge clk);
    irq_line = v;
    @(negedge clk);
    for (int n = 0; n < 2; n++) if (v[n] != irq_line_prev[n]) mp[n] = v[n];
    irq_line_prev = v;
  endtask
  logic [1:0] irq_line_prev = '0;

  task automatic chk_irq(input string tag);
    @(negedge clk);
    chk({tag, " irq"}, {31'h0, irq_out}, {31'h0, |(mp & ~mb)});
  endtask

  task automatic t_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; sec_en_strap = strap; irq_line = '0; irq_line_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mp = '0; mb = '0; mchen = 8'h04 | {4'b0, strap, 3'b0};
    chk_state("R1 reset");
    chk("R1 irq low", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_line;
    set_lines(2'b01);
    chk_state("R2 ch0 rise");
    chk("R6 latency irq still low", {31'h0, irq_out}, 32'h0);
    chk_irq("R6 ch0 pending");
    set_lines(2'b11);
    chk_state("R2 ch1 rise");
    set_lines(2'b10);
    chk_state("R2 ch0 fall");
    chk_irq("R6 ch1 only");
  endtask

  task automatic t_w1c;
    // channel 1 cleared via mode byte 0x71 bit 3, observed in 0x57
    cfg_wr(6'h1C, 32'h0000_0800, 4'b0010); mp[1] = 1'b0;
    chk_state("R3 clear ch1 via 0x71");
    chk_irq("R3 irq after clear");
    // channel 0 set, then cleared via legacy 0x50 bit 2
    set_lines(2'b11); // ch1 unchanged (still high), ch0 rises
    cfg_wr(6'h14, 32'h0000_0000, 4'b0001);
    chk_state("R3 zero write no effect");
    cfg_wr(6'h14, 32'h0000_0004, 4'b0001); mp[0] = 1'b0;
    chk_state("R3 clear ch0 via 0x50");
    set_lines(2'b00); set_lines(2'b11);
    cfg_wr(6'h15, 32'h1000_0000, 4'b1000); mp[1] = 1'b0;
    chk_state("R3 clear ch1 via 0x57");
  endtask

  task automatic t_lanes;
    set_lines(2'b00); set_lines(2'b11);
    cfg_wr(6'h1C, 32'hFFFF_FFFF, 4'b1101);
    chk_state("R4 disabled lane ignored");
    cfg_wr(6'h14, 32'h0000_5A04, 4'b0011); mp[0] = 1'b0; mchen = 8'h5A;
    chk_state("R4 clear plus chen same write");
    set_lines(2'b00); set_lines(2'b11);
    cfg_wr(6'h1C, 32'h0000_0C00, 4'b0010); mp = 2'b00;
    chk_state("R4 both cleared one write");
  endtask

  task automatic t_dma;
    set_lines(2'b00); set_lines(2'b11);
    @(negedge clk); dma_wr_en = 1'b1; dma_wdata = 8'hFF;
    @(negedge clk); dma_wr_en = 1'b0; mb = 2'b11;
    chk_state("R5 dma all ones");
    chk_irq("R6 both blocked");
    @(negedge clk); dma_wr_en = 1'b1; dma_wdata = 8'h10;
    @(negedge clk); dma_wr_en = 1'b0; mb = 2'b01;
    chk_state("R5 dma unblock ch1");
    chk_irq("R6 ch1 through");
    cfg_wr(6'h1C, 32'h0000_2000, 4'b0010);
    chk_state("R5 cfg cannot set block");
    @(negedge clk); dma_wr_en = 1'b1; dma_wdata = 8'h00;
    @(negedge clk); dma_wr_en = 1'b0; mb = 2'b00;
  endtask

  task automatic t_ro;
    logic [31:0] d;
    cfg_wr(6'h14, 32'hFFFF_FFFB, 4'b1111); mchen = 8'hFF;
    chk_state("R7 reserved bits 0x50");
    cfg_wr(6'h15, 32'hEFFF_FFFF, 4'b1111);
    chk_state("R7 reserved bits 0x57");
    cfg_wr(6'h14, 32'h0000_3300, 4'b0001);
    chk_state("R7 chen needs lane enable");
    cfg_wr(6'h00, 32'hFFFF_FFFF, 4'b1111);
    rd(6'h00, d); chk("R8 unmapped 0x00", d, 32'h0);
    rd(6'h1D, d); chk("R8 unmapped 0x74", d, 32'h0);
  endtask

  task automatic t_race;
    set_lines(2'b00);
    @(negedge clk);
    irq_line = 2'b01;
    cfg_wr_en = 1'b1; cfg_wr_addr = 6'h14; cfg_wdata = 32'h4; cfg_be = 4'b0001;
    @(negedge clk);
    cfg_wr_en = 1'b0; mp[0] = 1'b1; irq_line_prev = 2'b01;
    chk_state("R9 line wins over clear");
  endtask

  initial begin
    mp = '0; mb = '0; mchen = 8'h04;
    t_reset(1'b0);
    t_line;
    t_w1c;
    t_lanes;
    t_dma;
    t_ro;
    t_race;
    t_reset(1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule